// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block sits between a single DMA requester and a cache-line-oriented memory port. The requester hands over one transfer at a time. A transfer is a byte address, a byte count, a direction flag and a flag saying whether a response is wanted. The sequencer cuts the transfer into pieces that never cross a line boundary. It presents them to the memory side one at a time. It waits for each piece to be acknowledged (stores) or to return its line of data (loads) before it offers the next. Load data is collected into a local byte buffer and handed back with the response.

Only one transfer is ever in flight. A requester that asks while the sequencer is occupied is turned away at once and not queued. The sequencer remembers that someone was turned away and, when the active transfer ends, it raises a one-cycle retry hint. A test-mode input stops it from remembering. A drain output tells the surrounding logic when nothing is outstanding.

Top module: `dma_line_seq`

## Requirements
- R1: `req_ready` is high exactly when no transfer is active; a transfer with a length from 1 to MAX_LEN is taken in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle that follows.
- R2: A request with length 0 or above MAX_LEN raises `req_err` in its handshake cycle and is not started: `req_ready` stays high and `mem_valid` stays low.
- R3: While a transfer is active, `req_valid` raises `req_reject` in the same cycle; the rejected request is dropped, and no memory piece follows it once the active transfer is over.
- R4: A rejection (when `test_mode` is low) is remembered; `retry_pulse` is high for exactly one cycle, the first cycle in which `req_ready` is high again after the active transfer ends, and is not raised when no rejection was remembered. A rejection in the same cycle as the final memory return also produces the pulse.
- R5: The first piece has `mem_addr` equal to the start address, `mem_line_addr` equal to that address with its low log2(LINE_BYTES) bits cleared, and `mem_len` equal to the smaller of the length and LINE_BYTES minus the in-line offset.
- R6: Each later piece starts at start address plus the bytes already completed (line-aligned) with length equal to the smaller of the remaining bytes and LINE_BYTES; `mem_valid` is low from the cycle after a piece handshake until the cycle after its `mem_rsp_valid`, and a piece held by low `mem_ready` keeps its fields.
- R7: `mem_store` is 1 for writes and 0 for reads. For a write piece, byte lane j of `mem_wdata` (bits 8j+7:8j) carries request byte (done + j − off), where off is the in-line offset on the first piece and 0 later; request byte i sits at bits 8i+7:8i of `req_wdata`.
- R8: For a read, `resp_rdata` byte i equals the byte at address start+i taken from the returned lines (first piece from lane off onwards, later pieces from lane 0); bytes at or above the length are zero.
- R9: After the memory return that completes a transfer, `req_ready` is high in the next cycle and `resp_valid` is high for one cycle one clock later, with `resp_write` giving the direction, only when a response was requested.
- R10: `drained` is high only when no transfer is active and no response is pending or being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | When high, rejections are not remembered for a retry hint |
| req_valid | input | 1 | Requester offers a transfer |
| req_ready | output | 1 | Sequencer is idle and will take a transfer |
| req_addr | input | AW | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| req_need_resp | input | 1 | 1 = a completion response is wanted |
| req_wdata | input | MAX_LEN*8 | Write bytes, byte i in bits 8i+7:8i |
| req_err | output | 1 | Offered length is zero or too large |
| req_reject | output | 1 | Offer refused because a transfer is active |
| retry_pulse | output | 1 | One-cycle hint that a refused requester may try again |
| resp_valid | output | 1 | Completion response, one cycle |
| resp_write | output | 1 | Direction of the completed transfer |
| resp_rdata | output | MAX_LEN*8 | Gathered read bytes |
| mem_valid | output | 1 | A piece is offered to memory |
| mem_ready | input | 1 | Memory takes the piece |
| mem_addr | output | AW | Byte address of the piece |
| mem_line_addr | output | AW | Line-aligned address of the piece |
| mem_len | output | LEN_W | Byte count of the piece |
| mem_store | output | 1 | 1 = store piece, 0 = load piece |
| mem_wdata | output | LINE_BYTES*8 | Store data placed at its in-line lanes |
| mem_rsp_valid | input | 1 | Acknowledge or data return for the outstanding piece |
| mem_rsp_data | input | LINE_BYTES*8 | Full returned line |
| drained | output | 1 | Nothing outstanding |

## Verification
Two things meet in one cycle at the seam between transfers: the final memory return and a refusal, and then the response of the old transfer and the acceptance of a new one. The bench drives `req_valid` in the very cycle of the last `mem_rsp_valid` and expects both `req_reject` then and `retry_pulse` in the next cycle. It also offers a write in the first idle cycle after a read ends, and expects the read's response to carry the old read bytes while the new write's first piece is already on the memory side.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } mem_op_e;

endpackage

// File: rtl/dma_piece_gen.sv
module dma_piece_gen #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BUF_W     = MAX_LEN * 8
) (
    input  logic [AW-1:0]     start_addr,
    input  logic [LEN_W-1:0]  total_bytes,
    input  logic [LEN_W-1:0]  done_bytes,
    input  logic [BUF_W-1:0]  buf_data,
    output logic [AW-1:0]     piece_addr,
    output logic [AW-1:0]     piece_line,
    output logic [LEN_W-1:0]  piece_len,
    output logic [OFF_W-1:0]  piece_off,
    output logic [LINE_W-1:0] piece_wdata
);

    logic [OFF_W-1:0] in_off;
    logic             first_piece;
    logic [LEN_W:0]   room;
    logic [LEN_W:0]   remain;

    assign in_off      = start_addr[OFF_W-1:0];
    assign first_piece = (done_bytes == '0);
    assign room        = first_piece ? ((LEN_W+1)'(LINE_BYTES) - (LEN_W+1)'(in_off))
                                     : (LEN_W+1)'(LINE_BYTES);
    assign remain      = {1'b0, total_bytes} - {1'b0, done_bytes};
    assign piece_len   = (remain < room) ? remain[LEN_W-1:0] : room[LEN_W-1:0];
    assign piece_off   = first_piece ? in_off : '0;
    assign piece_addr  = start_addr + AW'(done_bytes);
    assign piece_line  = {piece_addr[AW-1:OFF_W], {OFF_W{1'b0}}};

    // Place buffer bytes into their lanes of the line.
    genvar j;
    generate
        for (j = 0; j < LINE_BYTES; j++) begin : g_lane
            int src;
            logic in_win;
            assign src    = int'(done_bytes) + j - int'(piece_off);
            assign in_win = (j >= int'(piece_off)) &&
                            (j < int'(piece_off) + int'(piece_len)) &&
                            (src >= 0) && (src < MAX_LEN);
            assign piece_wdata[8*j +: 8] = in_win ? buf_data[8*src +: 8] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/dma_read_gather.sv
module dma_read_gather #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BUF_W     = MAX_LEN * 8
) (
    input  logic [BUF_W-1:0]  buf_data,
    input  logic [LINE_W-1:0] line_data,
    input  logic [LEN_W-1:0]  done_bytes,
    input  logic [LEN_W-1:0]  issued_bytes,
    input  logic [OFF_W-1:0]  line_off,
    output logic [BUF_W-1:0]  buf_next
);

    // Each buffer byte picks its lane from the returned line when it
    // falls inside the piece just completed.
    genvar k;
    generate
        for (k = 0; k < MAX_LEN; k++) begin : g_byte
            int lane;
            logic hit;
            assign lane = k - int'(done_bytes) + int'(line_off);
            assign hit  = (k >= int'(done_bytes)) && (k < int'(issued_bytes)) &&
                          (lane >= 0) && (lane < LINE_BYTES);
            assign buf_next[8*k +: 8] = hit ? line_data[8*lane +: 8] : buf_data[8*k +: 8];
        end
    endgenerate

endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
    import dma_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BUF_W     = MAX_LEN * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_write,
    input  logic              req_need_resp,
    input  logic [BUF_W-1:0]  req_wdata,
    output logic              req_err,
    output logic              req_reject,
    output logic              retry_pulse,
    output logic              resp_valid,
    output logic              resp_write,
    output logic [BUF_W-1:0]  resp_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     mem_line_addr,
    output logic [LEN_W-1:0]  mem_len,
    output logic              mem_store,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data,
    output logic              drained
);

    typedef struct packed {
        logic             busy;
        logic             wait_rsp;
        logic [AW-1:0]    start;
        logic [LEN_W-1:0] total;
        logic [LEN_W-1:0] issued;
        logic [LEN_W-1:0] done_b;
        logic             write;
        logic             need_resp;
        logic             retry;
        logic             retry_pulse;
        logic             fin;
        logic             resp_valid;
        logic             resp_write;
        logic [BUF_W-1:0] buf_b;
        logic [BUF_W-1:0] resp_data;
    } seq_state_t;

    seq_state_t state_q, state_d;

    logic [AW-1:0]     p_addr;
    logic [AW-1:0]     p_line;
    logic [LEN_W-1:0]  p_len;
    logic [OFF_W-1:0]  p_off;
    logic [LINE_W-1:0] p_wdata;
    logic [BUF_W-1:0]  gathered;
    mem_op_e           cur_op;

    dma_piece_gen #(
        .AW         (AW),
        .LINE_BYTES (LINE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_piece (
        .start_addr  (state_q.start),
        .total_bytes (state_q.total),
        .done_bytes  (state_q.done_b),
        .buf_data    (state_q.buf_b),
        .piece_addr  (p_addr),
        .piece_line  (p_line),
        .piece_len   (p_len),
        .piece_off   (p_off),
        .piece_wdata (p_wdata)
    );

    dma_read_gather #(
        .LINE_BYTES (LINE_BYTES),
        .MAX_LEN    (MAX_LEN)
    ) u_gather (
        .buf_data     (state_q.buf_b),
        .line_data    (mem_rsp_data),
        .done_bytes   (state_q.done_b),
        .issued_bytes (state_q.issued),
        .line_off     (p_off),
        .buf_next     (gathered)
    );

    logic len_bad;
    logic take_req;
    logic refuse;
    logic piece_fire;
    logic rsp_take;
    logic finishing;
    logic note_retry;

    assign len_bad    = (req_len == '0) || (req_len > LEN_W'(MAX_LEN));
    assign take_req   = req_valid && !state_q.busy && !len_bad;
    assign refuse     = req_valid && state_q.busy;
    assign piece_fire = state_q.busy && !state_q.wait_rsp && mem_ready;
    assign rsp_take   = state_q.busy && state_q.wait_rsp && mem_rsp_valid;
    assign finishing  = rsp_take && (state_q.issued == state_q.total);
    assign note_retry = refuse && !test_mode;

    always_comb begin
        state_d             = state_q;
        state_d.fin         = 1'b0;
        state_d.retry_pulse = 1'b0;
        state_d.resp_valid  = state_q.fin && state_q.need_resp;
        if (state_q.fin) begin
            state_d.resp_write = state_q.write;
            state_d.resp_data  = state_q.buf_b;
        end

        if (take_req) begin
            state_d.busy      = 1'b1;
            state_d.wait_rsp  = 1'b0;
            state_d.start     = req_addr;
            state_d.total     = req_len;
            state_d.issued    = '0;
            state_d.done_b    = '0;
            state_d.write     = req_write;
            state_d.need_resp = req_need_resp;
            state_d.buf_b     = req_write ? req_wdata : '0;
        end

        if (piece_fire) begin
            state_d.wait_rsp = 1'b1;
            state_d.issued   = state_q.done_b + p_len;
        end

        if (rsp_take) begin
            state_d.wait_rsp = 1'b0;
            state_d.done_b   = state_q.issued;
            if (!state_q.write) begin
                state_d.buf_b = gathered;
            end
            if (finishing) begin
                // Busy drops first so the retried requester is taken at once.
                state_d.busy = 1'b0;
                state_d.fin  = 1'b1;
            end
        end

        if (finishing) begin
            state_d.retry_pulse = state_q.retry || note_retry;
            state_d.retry       = 1'b0;
        end else begin
            state_d.retry = state_q.retry || note_retry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cur_op        = state_q.write ? OP_STORE : OP_LOAD;
    assign req_ready     = !state_q.busy;
    assign req_err       = req_valid && !state_q.busy && len_bad;
    assign req_reject    = refuse;
    assign retry_pulse   = state_q.retry_pulse;
    assign resp_valid    = state_q.resp_valid;
    assign resp_write    = state_q.resp_write;
    assign resp_rdata    = state_q.resp_data;
    assign mem_valid     = state_q.busy && !state_q.wait_rsp;
    assign mem_addr      = p_addr;
    assign mem_line_addr = p_line;
    assign mem_len       = p_len;
    assign mem_store     = (cur_op == OP_STORE);
    assign mem_wdata     = p_wdata;
    assign drained       = !state_q.busy && !state_q.fin && !state_q.resp_valid;

endmodule

// File: rtl/dma_line_seq_chk.sv
module dma_line_seq_chk #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_LEN    = 256,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_err,
    input logic             req_reject,
    input logic             retry_pulse,
    input logic             resp_valid,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [AW-1:0]    mem_addr,
    input logic [LEN_W-1:0] mem_len,
    input logic             drained
);

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_err) |=> !req_ready);

    assert_bad_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_err) |=> (req_ready && !mem_valid));

    assert_reject_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> !req_ready);

    assert_retry_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |-> (req_ready && !mem_valid));

    assert_piece_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ((mem_len != '0) &&
                       (int'(mem_len) + int'(mem_addr[OFF_W-1:0]) <= LINE_BYTES)));

    assert_one_piece_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> !mem_valid);

    assert_hold_piece_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)));

    assert_resp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_drained_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> (req_ready && !resp_valid && !mem_valid));

endmodule

bind dma_line_seq dma_line_seq_chk #(
    .AW         (AW),
    .LINE_BYTES (LINE_BYTES),
    .MAX_LEN    (MAX_LEN)
) u_chk (.*);

// File: tb/dma_line_seq_tb.sv
module dma_line_seq_tb;

    localparam int AW     = 32;
    localparam int LINE   = 64;
    localparam int MAXL   = 256;
    localparam int LEN_W  = $clog2(MAXL + 1);
    localparam int LINE_W = LINE * 8;
    localparam int BUF_W  = MAXL * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              test_mode = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [AW-1:0]     req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_write = 1'b0;
    logic              req_need_resp = 1'b0;
    logic [BUF_W-1:0]  req_wdata = '0;
    logic              req_err;
    logic              req_reject;
    logic              retry_pulse;
    logic              resp_valid;
    logic              resp_write;
    logic [BUF_W-1:0]  resp_rdata;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic [AW-1:0]     mem_addr;
    logic [AW-1:0]     mem_line_addr;
    logic [LEN_W-1:0]  mem_len;
    logic              mem_store;
    logic [LINE_W-1:0] mem_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_data = '0;
    logic              drained;

    always #4 clk = ~clk;

    dma_line_seq #(.AW(AW), .LINE_BYTES(LINE), .MAX_LEN(MAXL)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_need_resp(req_need_resp),
        .req_wdata(req_wdata), .req_err(req_err), .req_reject(req_reject),
        .retry_pulse(retry_pulse), .resp_valid(resp_valid), .resp_write(resp_write),
        .resp_rdata(resp_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_line_addr(mem_line_addr), .mem_len(mem_len),
        .mem_store(mem_store), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .drained(drained)
    );

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] mem [0:4095];
    logic [7:0] rd_exp [0:MAXL-1];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        report();
        $finish;
    end

    task automatic fill_wdata(input int seed);
        for (int i = 0; i < MAXL; i++) req_wdata[8*i +: 8] = 8'(i * 13 + seed);
    endtask

    // Offer a transfer at a negedge; returns at the next negedge.
    task automatic start_req(input int a, input int len, input bit wr, input bit nr);
        if (!wr) for (int i = 0; i < len; i++) rd_exp[i] = mem[(a + i) % 4096];
        req_addr = AW'(a); req_len = LEN_W'(len); req_write = wr;
        req_need_resp = nr; req_valid = 1'b1;
        #1;
        chk("R1", "ready before accept", 64'(req_ready), 64'd1);
        chk("R2", "no error on good length", 64'(req_err), 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R1", "ready after accept", 64'(req_ready), 64'd0);
        chk("R10", "not drained while busy", 64'(drained), 64'd0);
    endtask

    // Serve every piece; rej: 0 none, 1 refusal mid-transfer, 2 refusal with final return.
    task automatic service(input int a, input int len, input bit wr, input int rej, input bit tm);
        int cur = 0;
        test_mode = tm;
        while (cur < len) begin
            int o = (cur == 0) ? (a % LINE) : 0;
            int plen = (len - cur < LINE - o) ? (len - cur) : (LINE - o);
            int pa = a + cur;
            int la = pa - (pa % LINE);
            int w = 0;
            while (!mem_valid && w < 20) begin @(negedge clk); #1; w++; end
            chk(cur == 0 ? "R5" : "R6", "piece addr", 64'(mem_addr), 64'(pa));
            chk(cur == 0 ? "R5" : "R6", "piece line addr", 64'(mem_line_addr), 64'(la));
            chk(cur == 0 ? "R5" : "R6", "piece len", 64'(mem_len), 64'(plen));
            chk("R7", "piece type", 64'(mem_store), 64'(wr));
            if (wr) begin
                int bad = 0;
                for (int k = 0; k < plen; k++) begin
                    if (mem_wdata[8*((pa % LINE) + k) +: 8] !== req_wdata[8*(cur + k) +: 8]) bad++;
                    mem[(pa + k) % 4096] = mem_wdata[8*((pa % LINE) + k) +: 8];
                end
                chk("R7", "store lane mismatches", 64'(bad), 64'd0);
            end
            // Hold one cycle with ready low first to see the piece stays put.
            mem_ready = 1'b0;
            @(negedge clk); #1;
            chk("R6", "piece held addr", 64'(mem_addr), 64'(pa));
            mem_ready = 1'b1;
            @(negedge clk);
            mem_ready = 1'b0;
            #1;
            chk("R6", "no piece while waiting", 64'(mem_valid), 64'd0);
            if (rej == 1 && cur == 0) begin
                req_valid = 1'b1; #1;
                chk("R3", "reject while busy", 64'(req_reject), 64'd1);
                @(negedge clk); req_valid = 1'b0; #1;
            end else begin
                @(negedge clk); #1;
            end
            chk("R6", "still waiting", 64'(mem_valid), 64'd0);
            for (int j = 0; j < LINE; j++) mem_rsp_data[8*j +: 8] = mem[(la + j) % 4096];
            mem_rsp_valid = 1'b1;
            if (rej == 2 && cur + plen >= len) begin
                req_valid = 1'b1; #1;
                chk("R4", "reject on final return", 64'(req_reject), 64'd1);
            end
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            req_valid = 1'b0;
            cur += plen;
        end
        #1;
        chk("R9", "ready after completion", 64'(req_ready), 64'd1);
        chk("R4", "retry pulse", 64'(retry_pulse), 64'((rej != 0) && !tm));
        chk("R9", "no response yet", 64'(resp_valid), 64'd0);
        chk("R10", "not drained at completion", 64'(drained), 64'd0);
        test_mode = 1'b0;
    endtask

    task automatic check_rdata(input int len, input string what);
        int bad = 0;
        for (int i = 0; i < MAXL; i++) begin
            if (i < len && resp_rdata[8*i +: 8] !== rd_exp[i]) bad++;
            if (i >= len && resp_rdata[8*i +: 8] !== 8'h00) bad++;
        end
        chk("R8", what, 64'(bad), 64'd0);
    endtask

    task automatic finish_req(input int len, input bit wr, input bit nr);
        @(negedge clk); #1;
        chk("R9", "response valid", 64'(resp_valid), 64'(nr));
        chk("R4", "retry pulse single", 64'(retry_pulse), 64'd0);
        chk("R3", "no piece after completion", 64'(mem_valid), 64'd0);
        if (nr) chk("R9", "response direction", 64'(resp_write), 64'(wr));
        if (nr && !wr) check_rdata(len, "read bytes");
        chk("R10", "drained vs pending response", 64'(drained), 64'(!nr));
        @(negedge clk); #1;
        chk("R9", "response one cycle", 64'(resp_valid), 64'd0);
        chk("R10", "drained when idle", 64'(drained), 64'd1);
        chk("R3", "refused request not queued", 64'(mem_valid), 64'd0);
    endtask

    task automatic run(input int a, input int len, input bit wr, input bit nr,
                       input int rej, input bit tm);
        start_req(a, len, wr, nr);
        service(a, len, wr, rej, tm);
        finish_req(len, wr, nr);
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "reset ready", 64'(req_ready), 64'd1);
        chk("R6", "reset no piece", 64'(mem_valid), 64'd0);
        chk("R9", "reset no response", 64'(resp_valid), 64'd0);
        chk("R10", "reset drained", 64'(drained), 64'd1);
        chk("R4", "reset no retry", 64'(retry_pulse), 64'd0);
    endtask

    task automatic t_bad_len(input int len);
        req_addr = AW'(32'h40); req_len = LEN_W'(len); req_valid = 1'b1;
        #1;
        chk("R2", "error flagged", 64'(req_err), 64'd1);
        @(negedge clk); req_valid = 1'b0; #1;
        chk("R2", "still ready", 64'(req_ready), 64'd1);
        chk("R2", "not started", 64'(mem_valid), 64'd0);
        @(negedge clk); #1;
        chk("R2", "still idle", 64'(drained), 64'd1);
    endtask

    task automatic t_back_to_back();
        fill_wdata(91);
        start_req(32'h3F0, 40, 1'b0, 1'b1);
        service(32'h3F0, 40, 1'b0, 0, 1'b0);
        // First idle cycle: a write is offered while the read response is pending.
        req_addr = AW'(32'h480); req_len = LEN_W'(20); req_write = 1'b1;
        req_need_resp = 1'b1; req_valid = 1'b1;
        #1;
        chk("R9", "accept in retry cycle", 64'(req_ready), 64'd1);
        @(negedge clk); req_valid = 1'b0; #1;
        chk("R9", "old response beside new piece", 64'(resp_valid), 64'd1);
        chk("R9", "old response is a read", 64'(resp_write), 64'd0);
        check_rdata(40, "old read bytes kept");
        chk("R5", "new piece offered", 64'(mem_valid), 64'd1);
        chk("R7", "new piece is a store", 64'(mem_store), 64'd1);
        service(32'h480, 20, 1'b1, 0, 1'b0);
        finish_req(20, 1'b1, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        run(32'h100, 64, 1'b0, 1'b1, 0, 1'b0);          // aligned line read
        run(32'h13A, 200, 1'b0, 1'b1, 1, 1'b0);         // 6+64+64+64+2, refusal mid
        fill_wdata(5);
        run(32'h205, 10, 1'b1, 1'b0, 0, 1'b0);          // short write, no response
        fill_wdata(17);
        run(32'h23C, 150, 1'b1, 1'b1, 2, 1'b0);         // 4+64+64+18, refusal on last
        run(32'h23C, 150, 1'b0, 1'b1, 0, 1'b0);         // read back the write
        run(32'h205, 10, 1'b0, 1'b1, 1, 1'b1);          // test mode: no retry hint
        t_bad_len(0);
        t_bad_len(MAXL + 1);
        run(32'h301, MAXL, 1'b0, 1'b1, 0, 1'b0);        // 63+64+64+64+1
        t_back_to_back();
        run(32'h480, 20, 1'b0, 1'b1, 0, 1'b0);          // read back the last write
        report();
        $finish;
    end

endmodule